// File: doc/BRIEF.md
# Micro Translation Cache

This block keeps a handful of recently completed virtual-to-physical page translations so that most accesses never reach the main TLB. It holds two separate, fully associative arrays: one serves instruction fetches and the other serves data accesses. Every lookup is combinational. In the same cycle as the request, the block returns a hit flag, the physical address and the permission level stored with the page. Pages are 4 KB. Entries carry no address-space identifier, so the surrounding logic must pulse the flush input whenever a TLB entry is rewritten or the current address space changes.

After the main TLB finishes a translation successfully, it hands the page over through the fill port. A fill is written into the selected array at that array's round-robin pointer and can be seen by lookups from the next cycle onward. The stored permission follows the page's dirty bit: a dirty page is stored as read/write, a clean page as read-only. A lookup asks for read-only level for a read and read/write level for a write. An entry only serves the request if its stored level is at least the level asked for. Addresses inside the directly mapped kernel window are never served from the cache. A bypass input shuts off both lookups and fills.

Top module: `micro_xlat_cache`

## Requirements
- R1: After reset every entry of both arrays is invalid, so every lookup misses. Whenever the block reports a miss, `lk_paddr` and `lk_perm` are both zero.
- R2: `lk_ifetch`=1 searches only the instruction array and `lk_ifetch`=0 searches only the data array. `fl_ifetch` picks the array in the same way for a fill. A page filled into one array is never a hit in the other.
- R3: An entry matches when its stored page number equals `lk_vaddr[31:12]`. On a hit, `lk_paddr` is the stored frame number placed in bits 31:12, with `lk_vaddr[11:0]` in bits 11:0.
- R4: Permission codes are 1 for read-only and 2 for read/write. A lookup with `lk_write`=0 requests level 1 and a lookup with `lk_write`=1 requests level 2. A hit needs a page match and a stored level at least as high as the requested one. On a hit, `lk_perm` returns the stored level.
- R5: A fill stores level 2 when `fl_dirty`=1 and level 1 when `fl_dirty`=0.
- R6: A lookup with `lk_vaddr[31:30]` = 2'b10 always misses. Addresses outside that window, including 2'b11, are looked up normally.
- R7: While `bypass_i`=1 no lookup hits and fills have no effect. A page offered during bypass still misses after bypass is released, and entries that were already stored are kept.
- R8: Each array has 4 entries. Fills write into each array in round-robin order starting at entry 0, so the fifth fill after a flush or reset overwrites the first page that was filled.
- R9: A `flush_i` pulse invalidates every entry of both arrays in one cycle and sets both round-robin pointers back to entry 0. A fill offered in the same cycle as a flush is dropped.
- R10: When several entries qualify (page match and enough permission), the entry with the lowest index supplies the result. An entry that matches the page but lacks the permission does not block a higher-index entry that qualifies.
- R11: A fill becomes visible to lookups on the cycle after the clock edge that accepts it. A lookup in the same cycle as the fill still misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Disables all lookups and fills |
| flush_i | input | 1 | Invalidates every entry of both arrays |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write (requests level 2) |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address, zero on miss |
| lk_perm | output | 2 | Stored permission level, zero on miss |
| fl_valid | input | 1 | Fill request |
| fl_ifetch | input | 1 | Fill targets the instruction array |
| fl_vpn | input | 20 | Virtual page number of the filled page |
| fl_pfn | input | 20 | Physical frame number of the filled page |
| fl_dirty | input | 1 | Dirty bit of the filled page |

## Verification
The assertions check the following on every cycle: misses come out with zeroed result fields, a hit is never granted in the kernel window or during bypass, a write never hits a read-only level, a hit keeps the page offset unchanged, a flush leaves nothing valid, round-robin pointers advance by one per accepted fill, and the priority select is never more than one-hot. Only the bench's scenarios can show the rest. These are array separation, the dirty-to-level mapping, the exact frame returned, which entry gets replaced after a wrap, the lowest-index choice among duplicate pages, the drop of a fill that collides with a flush, and the one-cycle delay before a fill can be seen.

// File: rtl/utc_pkg.sv
package utc_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int OFS_W    = 12;
    localparam int VPN_W    = VA_W - OFS_W;
    localparam int PFN_W    = PA_W - OFS_W;

    typedef logic [1:0] perm_t;
    localparam perm_t PERM_NONE = 2'd0;
    localparam perm_t PERM_RO   = 2'd1;
    localparam perm_t PERM_RW   = 2'd2;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } utc_ent_t;
endpackage

// File: rtl/utc_pick.sv
module utc_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     qual,
    output logic [N-1:0]     sel,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        sel = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (qual[i] && !any) begin
                sel[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R10
    AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((qual & (sel - 1'b1)) == '0)); // R10
endmodule

// File: rtl/utc_array.sv
module utc_array
    import utc_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  perm_t            fill_perm,
    input  logic [VPN_W-1:0] look_vpn,
    input  perm_t            look_req,
    output logic             look_hit,
    output logic [PFN_W-1:0] look_pfn,
    output perm_t            look_perm
);
    typedef struct packed {
        utc_ent_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]       ptr;
    } arr_st_t;

    arr_st_t st_d, st_q;

    logic [ENTRIES-1:0] qual;
    logic [ENTRIES-1:0] sel;
    logic [ENTRIES-1:0] vld_vec;
    logic               any_hit;
    logic [PTR_W-1:0]   hit_idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign vld_vec[i] = st_q.ent[i].vld;
        assign qual[i]    = st_q.ent[i].vld
                         && (st_q.ent[i].vpn == look_vpn)
                         && (st_q.ent[i].perm >= look_req);
    end

    utc_pick #(.N(ENTRIES)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (qual),
        .sel   (sel),
        .any   (any_hit),
        .idx   (hit_idx)
    );

    always_comb begin
        look_hit  = any_hit;
        look_pfn  = '0;
        look_perm = PERM_NONE;
        if (any_hit) begin
            look_pfn  = st_q.ent[hit_idx].pfn;
            look_perm = st_q.ent[hit_idx].perm;
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].vld = 1'b0;
            end
            st_d.ptr = '0;
        end else if (fill_en) begin
            st_d.ent[st_q.ptr].vld  = 1'b1;
            st_d.ent[st_q.ptr].vpn  = fill_vpn;
            st_d.ent[st_q.ptr].pfn  = fill_pfn;
            st_d.ent[st_q.ptr].perm = fill_perm;
            st_d.ptr = (st_q.ptr == PTR_W'(ENTRIES - 1)) ? '0
                                                         : st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0)); // R9
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=>
            (st_q.ptr == (($past(st_q.ptr) == PTR_W'(ENTRIES - 1)) ? '0
                          : $past(st_q.ptr) + PTR_W'(1)))); // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !flush) |=> $stable(st_q.ptr)); // R8
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> $countones(vld_vec) >= 1); // R11
endmodule

// File: rtl/micro_xlat_cache.sv
module micro_xlat_cache
    import utc_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,
    input  logic             flush_i,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_ifetch,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic [1:0]       lk_perm,
    input  logic             fl_valid,
    input  logic             fl_ifetch,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PFN_W-1:0] fl_pfn,
    input  logic             fl_dirty
);
    localparam int NUM_ARR = 2;  // index 0: data, index 1: instruction

    logic             kwin;
    logic             look_ok;
    perm_t            req_lvl;
    perm_t            fill_lvl;
    logic [NUM_ARR-1:0]   a_hit;
    logic [PFN_W-1:0]     a_pfn  [NUM_ARR];
    perm_t                a_perm [NUM_ARR];
    logic [NUM_ARR-1:0]   a_fill;

    assign kwin     = (lk_vaddr[VA_W-1 -: 2] == 2'b10);
    assign look_ok  = !bypass_i && !kwin;
    assign req_lvl  = lk_write ? PERM_RW : PERM_RO;
    assign fill_lvl = fl_dirty ? PERM_RW : PERM_RO;

    for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
        assign a_fill[g] = fl_valid && !bypass_i && (fl_ifetch == (g == 1));
        utc_array #(.ENTRIES(ENTRIES)) u_arr (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush_i),
            .fill_en   (a_fill[g]),
            .fill_vpn  (fl_vpn),
            .fill_pfn  (fl_pfn),
            .fill_perm (fill_lvl),
            .look_vpn  (lk_vaddr[VA_W-1:OFS_W]),
            .look_req  (req_lvl),
            .look_hit  (a_hit[g]),
            .look_pfn  (a_pfn[g]),
            .look_perm (a_perm[g])
        );
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_paddr = '0;
        lk_perm  = PERM_NONE;
        if (look_ok && a_hit[lk_ifetch]) begin
            lk_hit   = 1'b1;
            lk_paddr = {a_pfn[lk_ifetch], lk_vaddr[OFS_W-1:0]};
            lk_perm  = a_perm[lk_ifetch];
        end
    end

    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && lk_perm == 2'd0)); // R1
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0])); // R3
    AST_LEVEL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_perm == 2'd1 && !lk_write) || lk_perm == 2'd2)); // R4
    AST_KWIN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vaddr[VA_W-1 -: 2] == 2'b10) |-> !lk_hit); // R6
    AST_BYPASS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |-> !lk_hit); // R7
endmodule

// File: tb/sim_micro_xlat_cache.sv
module sim_micro_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass_i = 1'b0;
    logic        flush_i = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_ifetch = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [1:0]  lk_perm;
    logic        fl_valid = 1'b0;
    logic        fl_ifetch = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [19:0] fl_pfn = '0;
    logic        fl_dirty = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    micro_xlat_cache u0 (.*);

    typedef struct packed {
        logic        is_look;  // 0: fill, 1: lookup and compare
        logic        ifc;
        logic        wr;       // write for lookups, dirty for fills
        logic [31:0] va;
        logic [31:0] pa;       // fill frame base / expected paddr
        logic        eh;
        logic [1:0]  ep;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,32'h0040_1000,32'h1234_5000,1'b0,2'd0,4'd5},  // R5 clean data fill
        '{1'b1,1'b0,1'b0,32'h0040_1abc,32'h1234_5abc,1'b1,2'd1,4'd3},  // R3 R5
        '{1'b1,1'b0,1'b1,32'h0040_1abc,32'h0000_0000,1'b0,2'd0,4'd4},  // R4 write to RO
        '{1'b1,1'b1,1'b0,32'h0040_1abc,32'h0000_0000,1'b0,2'd0,4'd2},  // R2 other array
        '{1'b0,1'b1,1'b1,32'h0040_1000,32'h0777_7000,1'b0,2'd0,4'd5},  // R5 dirty instr fill
        '{1'b1,1'b1,1'b1,32'h0040_1004,32'h0777_7004,1'b1,2'd2,4'd4},  // R4 R5
        '{1'b1,1'b1,1'b0,32'h0040_1004,32'h0777_7004,1'b1,2'd2,4'd4},  // R4 RW serves read
        '{1'b1,1'b0,1'b0,32'h0040_2000,32'h0000_0000,1'b0,2'd0,4'd3},  // R3 other page
        '{1'b0,1'b0,1'b1,32'h8000_5000,32'h0000_5000,1'b0,2'd0,4'd6},  // R6 fill in window
        '{1'b1,1'b0,1'b0,32'h8000_5010,32'h0000_0000,1'b0,2'd0,4'd6},  // R6 window misses
        '{1'b0,1'b0,1'b1,32'hC000_3000,32'h0abc_d000,1'b0,2'd0,4'd6},  // R6
        '{1'b1,1'b0,1'b1,32'hC000_3fff,32'h0abc_dfff,1'b1,2'd2,4'd6},  // R6 2'b11 mapped
        '{1'b0,1'b0,1'b1,32'h0040_1000,32'h5555_5000,1'b0,2'd0,4'd10}, // R10 duplicate in entry 3
        '{1'b1,1'b0,1'b0,32'h0040_1000,32'h1234_5000,1'b1,2'd1,4'd10}, // R10 lowest index
        '{1'b1,1'b0,1'b1,32'h0040_1000,32'h5555_5000,1'b1,2'd2,4'd10}, // R10 skip weak entry
        '{1'b0,1'b0,1'b0,32'h0000_9000,32'h0009_9000,1'b0,2'd0,4'd8},  // R8 wraps to entry 0
        '{1'b1,1'b0,1'b0,32'h0040_1000,32'h5555_5000,1'b1,2'd2,4'd8},  // R8 entry 0 replaced
        '{1'b1,1'b0,1'b0,32'h0000_9123,32'h0009_9123,1'b1,2'd1,4'd8}   // R8
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic look(input logic ifc, input logic wr, input logic [31:0] va);
        @(negedge clk);
        lk_ifetch = ifc;
        lk_write  = wr;
        lk_vaddr  = va;
        #1;
    endtask

    task automatic expect_res(input string rq, input logic eh,
                              input logic [1:0] ep, input logic [31:0] epa);
        chk(rq, "hit",   {31'd0, lk_hit}, {31'd0, eh});
        chk(rq, "perm",  {30'd0, lk_perm}, {30'd0, ep});
        chk(rq, "paddr", lk_paddr, epa);
    endtask

    task automatic fill(input logic ifc, input logic dirty,
                        input logic [31:0] va, input logic [31:0] pa);
        @(negedge clk);
        fl_valid  = 1'b1;
        fl_ifetch = ifc;
        fl_dirty  = dirty;
        fl_vpn    = va[31:12];
        fl_pfn    = pa[31:12];
        @(negedge clk);
        fl_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, zeroed miss outputs
        look(1'b0, 1'b0, 32'h0040_1000);
        expect_res("R1", 1'b0, 2'd0, 32'h0);
        look(1'b1, 1'b0, 32'h0000_0000);
        expect_res("R1", 1'b0, 2'd0, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].is_look) begin
                look(VEC[k].ifc, VEC[k].wr, VEC[k].va);
                expect_res($sformatf("R%0d", VEC[k].rq), VEC[k].eh, VEC[k].ep, VEC[k].pa);
            end else begin
                fill(VEC[k].ifc, VEC[k].wr, VEC[k].va, VEC[k].pa);
            end
        end

        // R11: fill not visible in its own cycle, visible the next
        @(negedge clk);
        fl_valid = 1'b1; fl_ifetch = 1'b1; fl_dirty = 1'b0;
        fl_vpn = 20'h00100; fl_pfn = 20'h00200;
        lk_ifetch = 1'b1; lk_write = 1'b0; lk_vaddr = 32'h0010_0040;
        #1;
        expect_res("R11", 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        fl_valid = 1'b0;
        #1;
        expect_res("R11", 1'b1, 2'd1, 32'h0020_0040);

        // R7: bypass blocks hits and fills, keeps stored entries
        bypass_i = 1'b1;
        look(1'b1, 1'b0, 32'h0040_1000);
        expect_res("R7", 1'b0, 2'd0, 32'h0);
        fill(1'b1, 1'b1, 32'h0030_0000, 32'h0031_0000);
        bypass_i = 1'b0;
        look(1'b1, 1'b0, 32'h0030_0000);
        expect_res("R7", 1'b0, 2'd0, 32'h0);
        look(1'b1, 1'b0, 32'h0040_1000);
        expect_res("R7", 1'b1, 2'd2, 32'h0777_7000);

        // R9: flush clears both arrays and drops a colliding fill
        @(negedge clk);
        flush_i = 1'b1;
        fl_valid = 1'b1; fl_ifetch = 1'b0; fl_dirty = 1'b1;
        fl_vpn = 20'h00600; fl_pfn = 20'h00601;
        @(negedge clk);
        flush_i = 1'b0; fl_valid = 1'b0;
        look(1'b0, 1'b0, 32'h0000_9123);
        expect_res("R9", 1'b0, 2'd0, 32'h0);
        look(1'b1, 1'b0, 32'h0040_1000);
        expect_res("R9", 1'b0, 2'd0, 32'h0);
        look(1'b0, 1'b0, 32'h0060_0000);
        expect_res("R9", 1'b0, 2'd0, 32'h0);

        // R8 R9: pointer restarts at entry 0 after the flush
        for (int p = 0; p < 5; p++) begin
            fill(1'b0, 1'b0, 32'h00A0_0000 + (p << 12), 32'h00B0_0000 + (p << 12));
        end
        look(1'b0, 1'b0, 32'h00A0_0000);
        expect_res("R8", 1'b0, 2'd0, 32'h0);
        look(1'b0, 1'b0, 32'h00A0_1008);
        expect_res("R9", 1'b1, 2'd1, 32'h00B0_1008);
        look(1'b0, 1'b0, 32'h00A0_4010);
        expect_res("R8", 1'b1, 2'd1, 32'h00B0_4010);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule